// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

This block holds eight independent interval timers behind a small byte-wide register port. Each channel owns a 16-bit down-counter, a 16-bit reload value, a time-out flag, and an interrupt line. A counter steps down by one on each step event. A step event is either a tick from one of two shared 8-bit prescalers, or a rising edge on the channel's own trigger pin when the channel is in triggered mode. When a step arrives while the counter is at zero, the channel raises its flag and reloads.

Software turns the whole block on with one run bit and turns each channel on with its own bit. It can copy the reload value into a running counter at any time with a write-one strobe. A per-channel hold bit is latched whenever a channel is (re)loaded, and a latched hold freezes that counter. The interrupt of each channel is its flag gated by an interrupt-enable bit.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset every register reads 0 and all irq lines are low. The map uses 6-bit addresses:
  - 0x00 run (bit 0)
  - 0x01 channel on
  - 0x02 time-base select
  - 0x03 reload strobe
  - 0x04 hold
  - 0x05 trigger mode
  - 0x06 irq enable
  - 0x07 flags
  - 0x08 and 0x09 prescaler A and B reload values
  - 0x10+2n and 0x11+2n low and high byte of channel n's reload value
  - 0x20+2n and 0x21+2n low and high byte of channel n's counter (read only)
  
  Bit n of each per-channel byte belongs to channel n. Writable registers read back what was written.
- R2: A prescaler with reload value P emits a one-cycle tick every P+1 cycles while the block runs. A free-running channel with reload value L and select bit s counts on prescaler A (s=0) or B (s=1), and its flag sets every (P+1)*(L+1) cycles.
- R3: On a step event a channel at zero sets its flag and reloads. On a step event at any other value it decrements by one. Otherwise it keeps its value.
- R4: When a channel becomes active (run and channel-on both 1, after either bit was 0), its counter is loaded from its reload value one cycle later.
- R5: Writing 1 to bit n of 0x03 loads channel n's counter from its reload value, but only while run and channel n's on bit are both 1. Writing 0 changes nothing.
- R6: Address 0x03 always reads 0.
- R7: The reload strobe acts on channels in triggered mode exactly as on free-running channels.
- R8: In triggered mode (bit n of 0x05 set), channel n steps only on a rising edge of trig_in[n] and ignores prescaler ticks.
- R9: A channel whose on bit is 0 has its flag cleared.
- R10: While run is 0, all counters and prescalers keep their values and no flag sets.
- R11: Writing 1 to a flag bit at 0x07 clears it, and writing 0 leaves it unchanged. A flag set in the same cycle wins over its clear.
- R12: irq[n] is high exactly when flag n and irq-enable bit n are both 1.
- R13: Each load (R4 or R5) copies the channel's bit of 0x04 into a stop latch. While that latch is 1, the counter holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe, acts at the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| trig_in | input | 8 | Per-channel step trigger for triggered mode |
| irq | output | 8 | Per-channel interrupt request |

## Verification
The counting function is tried four ways:
- Randomly drawn prescaler and reload values on randomly picked channels, with the select bit alternating. The exact flag spacing separates a wrong base choice or an off-by-one reload from correct behaviour.
- Triggered counting with the tick running every cycle. Counts that move only with edges show whether ticks leak into triggered mode.
- Held counters, which separate the hold latch from the reload strobe.
- A stopped module, which must freeze every value.

// File: rtl/pit_pkg.sv
// Shared constants for the periodic interrupt timer: register address
// map and time-base count. Assumes byte-wide registers and at most 8
// channels, with 16-bit counters split over two consecutive addresses.
package pit_pkg;
    localparam int unsigned ADDR_W    = 6;
    localparam int unsigned NUM_BASES = 2;
    localparam int unsigned SEL_W     = $clog2(NUM_BASES);

    localparam logic [ADDR_W-1:0] A_RUN    = 6'h00;
    localparam logic [ADDR_W-1:0] A_CHON   = 6'h01;
    localparam logic [ADDR_W-1:0] A_BSEL   = 6'h02;
    localparam logic [ADDR_W-1:0] A_RELOAD = 6'h03;
    localparam logic [ADDR_W-1:0] A_HOLD   = 6'h04;
    localparam logic [ADDR_W-1:0] A_TRIG   = 6'h05;
    localparam logic [ADDR_W-1:0] A_IEN    = 6'h06;
    localparam logic [ADDR_W-1:0] A_FLAG   = 6'h07;
    localparam int unsigned       PRE_BASE  = 'h08;
    localparam int unsigned       LOAD_BASE = 'h10;
    localparam int unsigned       CNT_BASE  = 'h20;
endpackage

// File: rtl/pit_prescaler.sv
// Time-base prescaler: a down-counter that emits a one-cycle tick while at
// zero and then restarts from its reload value. Assumes the reload value
// is static or that a change may take effect only at the next wrap.
module pit_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] reload,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q == '0);

    // Count down while running, restart from reload after the zero cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (run) begin
            if (pcnt_q == '0) begin
                pcnt_q <= reload;
            end else begin
                pcnt_q <= pcnt_q - PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/pit_channel.sv
// One timer channel: down-counter, stop latch, trigger edge detector and
// time-out flag. Assumes trig_in is synchronous to clk and that force_ld
// and flag_clr are single-cycle strobes from the register block.
module pit_channel
    import pit_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 ch_on,
    input  logic [NUM_BASES-1:0] ticks,
    input  logic [SEL_W-1:0]     base_sel,
    input  logic                 trig_mode,
    input  logic                 trig_in,
    input  logic                 hold_shadow,
    input  logic                 force_ld,
    input  logic                 flag_clr,
    input  logic [CNT_W-1:0]     load,
    output logic [CNT_W-1:0]     cnt,
    output logic                 flag
);
    logic             active;
    logic             active_q;
    logic             start;
    logic             reload_now;
    logic             trig_q;
    logic             step;
    logic             counting;
    logic             expire;
    logic             stop_q;
    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;

    assign active     = run & ch_on;
    assign start      = active & ~active_q;
    assign reload_now = start | (force_ld & active);
    assign step       = trig_mode ? (trig_in & ~trig_q) : ticks[base_sel];
    assign counting   = active & ~stop_q & step & ~reload_now;
    assign expire     = counting & (cnt_q == '0);

    // Remember last activity state and trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            trig_q   <= 1'b0;
        end else begin
            active_q <= active;
            trig_q   <= trig_in;
        end
    end

    // Load on start or strobe, otherwise step down or wrap to reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload_now) begin
            cnt_q <= load;
        end else if (counting) begin
            cnt_q <= (cnt_q == '0) ? load : cnt_q - CNT_W'(1);
        end
    end

    // Latch the hold request whenever the counter is (re)loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (reload_now) begin
            stop_q <= hold_shadow;
        end
    end

    // Flag: cleared by channel off, set on expiry, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!ch_on) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;
endmodule

// File: rtl/pit_regs.sv
// Register file for the timer: control bytes, prescaler and channel reload
// values, write strobes and the combinational read multiplexer. Assumes
// NUM_CH <= 8, PRE_W <= 8 and 8 < CNT_W <= 16.
module pit_regs
    import pit_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PRE_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              wr_en,
    input  logic [7:0]                        wdata,
    output logic [7:0]                        rdata,
    input  logic [NUM_CH-1:0]                 flags_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]      cnt_i,
    output logic                              run_o,
    output logic [NUM_CH-1:0]                 ch_on_o,
    output logic [NUM_CH-1:0]                 bsel_o,
    output logic [NUM_CH-1:0]                 hold_o,
    output logic [NUM_CH-1:0]                 trig_mode_o,
    output logic [NUM_CH-1:0]                 irq_en_o,
    output logic [NUM_BASES-1:0][PRE_W-1:0]   pre_load_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]      load_o,
    output logic [NUM_CH-1:0]                 force_o,
    output logic [NUM_CH-1:0]                 flag_clr_o
);
    localparam int unsigned HI_W = CNT_W - 8;

    logic                            run_q;
    logic [NUM_CH-1:0]               ch_on_q;
    logic [NUM_CH-1:0]               bsel_q;
    logic [NUM_CH-1:0]               hold_q;
    logic [NUM_CH-1:0]               trig_q;
    logic [NUM_CH-1:0]               ien_q;
    logic [NUM_BASES-1:0][PRE_W-1:0] pre_q;
    logic [NUM_CH-1:0][CNT_W-1:0]    load_q;

    // Control byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            ch_on_q <= '0;
            bsel_q  <= '0;
            hold_q  <= '0;
            trig_q  <= '0;
            ien_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                A_RUN:   run_q   <= wdata[0];
                A_CHON:  ch_on_q <= wdata[NUM_CH-1:0];
                A_BSEL:  bsel_q  <= wdata[NUM_CH-1:0];
                A_HOLD:  hold_q  <= wdata[NUM_CH-1:0];
                A_TRIG:  trig_q  <= wdata[NUM_CH-1:0];
                A_IEN:   ien_q   <= wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    // Prescaler reload values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < int'(NUM_BASES); b++) begin
                if (addr == ADDR_W'(PRE_BASE + b)) begin
                    pre_q[b] <= wdata[PRE_W-1:0];
                end
            end
        end
    end

    // Channel reload values, low byte at even and high byte at odd address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < int'(NUM_CH); c++) begin
                if (addr == ADDR_W'(LOAD_BASE + 2 * c)) begin
                    load_q[c][7:0] <= wdata;
                end
                if (addr == ADDR_W'(LOAD_BASE + 2 * c + 1)) begin
                    load_q[c][CNT_W-1:8] <= wdata[HI_W-1:0];
                end
            end
        end
    end

    // Write-one strobes for reload and flag clear.
    always_comb begin
        force_o    = '0;
        flag_clr_o = '0;
        if (wr_en && addr == A_RELOAD) force_o    = wdata[NUM_CH-1:0];
        if (wr_en && addr == A_FLAG)   flag_clr_o = wdata[NUM_CH-1:0];
    end

    // Read multiplexer; unmapped addresses and the strobe register read 0.
    always_comb begin
        rdata = '0;
        case (addr)
            A_RUN:   rdata[0]          = run_q;
            A_CHON:  rdata[NUM_CH-1:0] = ch_on_q;
            A_BSEL:  rdata[NUM_CH-1:0] = bsel_q;
            A_HOLD:  rdata[NUM_CH-1:0] = hold_q;
            A_TRIG:  rdata[NUM_CH-1:0] = trig_q;
            A_IEN:   rdata[NUM_CH-1:0] = ien_q;
            A_FLAG:  rdata[NUM_CH-1:0] = flags_i;
            default: ;
        endcase
        for (int b = 0; b < int'(NUM_BASES); b++) begin
            if (addr == ADDR_W'(PRE_BASE + b)) rdata[PRE_W-1:0] = pre_q[b];
        end
        for (int c = 0; c < int'(NUM_CH); c++) begin
            if (addr == ADDR_W'(LOAD_BASE + 2 * c))     rdata = load_q[c][7:0];
            if (addr == ADDR_W'(LOAD_BASE + 2 * c + 1)) rdata[HI_W-1:0] = load_q[c][CNT_W-1:8];
            if (addr == ADDR_W'(CNT_BASE + 2 * c))      rdata = cnt_i[c][7:0];
            if (addr == ADDR_W'(CNT_BASE + 2 * c + 1))  rdata[HI_W-1:0] = cnt_i[c][CNT_W-1:8];
        end
    end

    assign run_o       = run_q;
    assign ch_on_o     = ch_on_q;
    assign bsel_o      = bsel_q;
    assign hold_o      = hold_q;
    assign trig_mode_o = trig_q;
    assign irq_en_o    = ien_q;
    assign pre_load_o  = pre_q;
    assign load_o      = load_q;
endmodule

// File: rtl/periodic_irq_timer.sv
// Top of the multi-channel periodic interrupt timer: register file, two
// shared prescalers and NUM_CH channels. Assumes a single clock domain
// and triggers already synchronised to it.
module periodic_irq_timer
    import pit_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NUM_CH-1:0] trig_in,
    output logic [NUM_CH-1:0] irq
);
    logic                            run_q;
    logic [NUM_CH-1:0]               ch_on_q;
    logic [NUM_CH-1:0]               bsel_q;
    logic [NUM_CH-1:0]               hold_q;
    logic [NUM_CH-1:0]               trig_mode_q;
    logic [NUM_CH-1:0]               irq_en_q;
    logic [NUM_BASES-1:0][PRE_W-1:0] pre_load;
    logic [NUM_CH-1:0][CNT_W-1:0]    load_v;
    logic [NUM_CH-1:0]               force_v;
    logic [NUM_CH-1:0]               flag_clr_v;
    logic [NUM_CH-1:0]               flag_v;
    logic [NUM_CH-1:0][CNT_W-1:0]    cnt_v;
    logic [NUM_BASES-1:0]            tick_v;

    pit_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .PRE_W  (PRE_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .wr_en       (reg_wr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .flags_i     (flag_v),
        .cnt_i       (cnt_v),
        .run_o       (run_q),
        .ch_on_o     (ch_on_q),
        .bsel_o      (bsel_q),
        .hold_o      (hold_q),
        .trig_mode_o (trig_mode_q),
        .irq_en_o    (irq_en_q),
        .pre_load_o  (pre_load),
        .load_o      (load_v),
        .force_o     (force_v),
        .flag_clr_o  (flag_clr_v)
    );

    for (genvar b = 0; b < int'(NUM_BASES); b++) begin : g_base
        pit_prescaler #(
            .PRE_W (PRE_W)
        ) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q),
            .reload (pre_load[b]),
            .tick   (tick_v[b])
        );
    end

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_chan
        pit_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (run_q),
            .ch_on       (ch_on_q[c]),
            .ticks       (tick_v),
            .base_sel    (SEL_W'(bsel_q[c])),
            .trig_mode   (trig_mode_q[c]),
            .trig_in     (trig_in[c]),
            .hold_shadow (hold_q[c]),
            .force_ld    (force_v[c]),
            .flag_clr    (flag_clr_v[c]),
            .load        (load_v[c]),
            .cnt         (cnt_v[c]),
            .flag        (flag_v[c])
        );
    end

    assign irq = flag_v & irq_en_q;
endmodule

// File: rtl/pit_checker.sv
// Property checker for the periodic interrupt timer, bound to the top.
// Observes the register port, run and channel-on state, counters, reload
// values and flags.
module pit_checker
    import pit_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         run,
    input logic [NUM_CH-1:0]            chan_on,
    input logic [NUM_CH-1:0]            flags,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] load,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [7:0]                   reg_rdata
);
    assert_rd_reload_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_RELOAD) |-> (reg_rdata == 8'h00));

    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == $past(cnt)));

    assert_no_flag_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((flags & ~$past(flags)) == '0));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flags & ~$past(chan_on)) == '0));

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_chk
        assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> ((cnt[i] == $past(cnt[i])) ||
                       (cnt[i] == $past(cnt[i]) - CNT_W'(1)) ||
                       (cnt[i] == $past(load[i]))));

        assert_flag_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> ($past(cnt[i]) == '0));
    end
endmodule

bind periodic_irq_timer pit_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .chan_on   (ch_on_q),
    .flags     (flag_v),
    .cnt       (cnt_v),
    .load      (load_v),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/periodic_irq_timer_tb.sv
// Self-checking bench: directed corner cases followed by seeded random
// period measurements on the free-running path.
module periodic_irq_timer_tb;
    localparam logic [5:0] RA_RUN    = 6'h00;
    localparam logic [5:0] RA_CHON   = 6'h01;
    localparam logic [5:0] RA_BSEL   = 6'h02;
    localparam logic [5:0] RA_RELOAD = 6'h03;
    localparam logic [5:0] RA_HOLD   = 6'h04;
    localparam logic [5:0] RA_TRIG   = 6'h05;
    localparam logic [5:0] RA_IEN    = 6'h06;
    localparam logic [5:0] RA_FLAG   = 6'h07;
    localparam logic [5:0] RA_PREA   = 6'h08;
    localparam logic [5:0] RA_PREB   = 6'h09;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] trig_in = '0;
    logic [7:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    periodic_irq_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_in   (trig_in),
        .irq       (irq)
    );

    always #4ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_period(input int p, input int l);
        return (p + 1) * (l + 1);
    endfunction

    function automatic logic [5:0] load_addr(input int ch, input int hi);
        return 6'(16 + 2 * ch + hi);
    endfunction

    function automatic logic [5:0] cnt_addr(input int ch, input int hi);
        return 6'(32 + 2 * ch + hi);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1ns;
        d = reg_rdata;
    endtask

    task automatic rd16(input int ch, output logic [15:0] v);
        logic [7:0] lo;
        logic [7:0] hi;
        rd(cnt_addr(ch, 0), lo);
        rd(cnt_addr(ch, 1), hi);
        v = {hi, lo};
    endtask

    task automatic pulse(input int ch);
        @(negedge clk);
        trig_in[ch] = 1'b1;
        @(negedge clk);
        trig_in[ch] = 1'b0;
    endtask

    task automatic wait_irq(input int ch, output int t);
        t = -1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (irq[ch]) begin
                t = cyc;
                reg_addr  = RA_FLAG;
                reg_wdata = 8'(1 << ch);
                reg_wr    = 1'b1;
                @(negedge clk);
                reg_wr    = 1'b0;
                break;
            end
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  d;
        logic [7:0]  f1;
        logic [7:0]  f2;
        logic [15:0] v;
        logic [15:0] v2;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and readback
        for (int a = 0; a < 10; a++) begin
            rd(6'(a), d);
            chk("R1 reset value", d, 0);
        end
        rd(load_addr(3, 1), d);
        chk("R1 reload byte reset", d, 0);
        rd(cnt_addr(5, 0), d);
        chk("R1 counter reset", d, 0);
        #1ns;
        chk("R1 irq reset", irq, 0);
        wr(RA_IEN, 8'hA5);
        rd(RA_IEN, d);
        chk("R1 irq enable readback", d, 8'hA5);
        wr(RA_IEN, 8'h00);
        wr(load_addr(0, 0), 8'h34);
        wr(load_addr(0, 1), 8'h12);
        rd(load_addr(0, 1), d);
        chk("R1 reload high readback", d, 8'h12);

        // R6 and R5: strobe reads zero, no action while module stopped
        wr(RA_CHON, 8'h01);
        wr(RA_RELOAD, 8'hFF);
        rd(RA_RELOAD, d);
        chk("R6 strobe reads zero", d, 0);
        rd16(0, v);
        chk("R5 no load while run off", v, 16'h0000);

        // R4 and R13: activation loads counter, hold latch freezes it
        wr(RA_HOLD, 8'h01);
        wr(RA_RUN, 8'h01);
        rd16(0, v);
        chk("R4 load on activation", v, 16'h1234);
        repeat (20) @(negedge clk);
        rd16(0, v);
        chk("R13 held counter", v, 16'h1234);

        // R5: zero write ignored, one write loads
        wr(load_addr(0, 0), 8'h42);
        wr(load_addr(0, 1), 8'h00);
        wr(RA_RELOAD, 8'h00);
        rd16(0, v);
        chk("R5 zero write no effect", v, 16'h1234);
        wr(RA_RELOAD, 8'h01);
        rd16(0, v);
        chk("R5 strobe loads counter", v, 16'h0042);

        // R13: strobe reloads the stop latch from the hold register
        wr(RA_HOLD, 8'h00);
        wr(RA_RELOAD, 8'h01);
        repeat (5) @(negedge clk);
        rd16(0, v);
        chk("R13 hold released by strobe", (v < 16'h0042) ? 1 : 0, 1);

        // R8 and R7: triggered channel 1
        wr(RA_TRIG, 8'h02);
        wr(load_addr(1, 0), 8'h05);
        wr(load_addr(1, 1), 8'h00);
        wr(RA_CHON, 8'h03);
        repeat (20) @(negedge clk);
        rd16(1, v);
        chk("R8 ticks ignored in triggered mode", v, 5);
        repeat (3) pulse(1);
        rd16(1, v);
        chk("R8 counts trigger edges", v, 2);
        wr(load_addr(1, 0), 8'h09);
        wr(RA_RELOAD, 8'h02);
        rd16(1, v);
        chk("R7 strobe on triggered channel", v, 9);
        repeat (9) pulse(1);
        rd(RA_FLAG, d);
        chk("R3 no flag before zero step", d[1], 0);
        rd16(1, v);
        chk("R3 counter reached zero", v, 0);
        pulse(1);
        rd(RA_FLAG, d);
        chk("R3 flag on step at zero", d[1], 1);
        rd16(1, v);
        chk("R3 reload after expiry", v, 9);

        // R11: write-one clear
        wr(RA_FLAG, 8'h00);
        rd(RA_FLAG, d);
        chk("R11 zero write keeps flag", d[1], 1);
        wr(RA_FLAG, 8'h02);
        rd(RA_FLAG, d);
        chk("R11 one write clears flag", d[1], 0);

        // R12: interrupt gating
        repeat (10) pulse(1);
        rd(RA_FLAG, d);
        chk("R12 flag set again", d[1], 1);
        chk("R12 irq masked", irq[1], 0);
        wr(RA_IEN, 8'h02);
        #1ns;
        chk("R12 irq enabled", irq[1], 1);

        // R9: channel off clears flag
        wr(RA_CHON, 8'h01);
        rd(RA_FLAG, d);
        chk("R9 flag cleared by channel off", d[1], 0);
        chk("R9 irq low after channel off", irq[1], 0);

        // R10: stopped module freezes counters and flags
        wr(RA_RUN, 8'h00);
        rd16(0, v);
        rd(RA_FLAG, f1);
        repeat (40) @(negedge clk);
        rd16(0, v2);
        rd(RA_FLAG, f2);
        chk("R10 counter frozen", v2, v);
        chk("R10 flags unchanged", f2, f1);

        // R2: seeded random period measurement on both time bases
        void'($urandom(32'd20240611));
        for (int it = 0; it < 8; it++) begin
            int ch;
            int p;
            int l;
            int sel;
            int t1;
            int t2;
            int t3;
            ch  = int'($urandom % 8);
            p   = 1 + int'($urandom % 4);
            l   = 1 + int'($urandom % 6);
            sel = it % 2;
            wr(RA_RUN, 8'h00);
            wr(RA_CHON, 8'h00);
            wr(RA_FLAG, 8'hFF);
            wr(RA_TRIG, 8'h00);
            wr(RA_HOLD, 8'h00);
            wr(RA_BSEL, 8'(sel << ch));
            wr(RA_PREA, 8'(sel ? p + 3 : p));
            wr(RA_PREB, 8'(sel ? p : p + 3));
            wr(load_addr(ch, 0), 8'(l));
            wr(load_addr(ch, 1), 8'h00);
            wr(RA_IEN, 8'(1 << ch));
            wr(RA_CHON, 8'(1 << ch));
            wr(RA_RUN, 8'h01);
            wait_irq(ch, t1);
            wait_irq(ch, t2);
            wait_irq(ch, t3);
            chk("R2 flag seen", (t1 >= 0 && t2 >= 0 && t3 >= 0) ? 1 : 0, 1);
            chk("R2 period on selected base", t3 - t2, exp_period(p, l));
        end

        finish_run();
    end
endmodule